// File: doc/BRIEF.md
# Asynchronous DRAM Device Emulator

This block stands in for a small asynchronous DRAM part on the device side of its pins. It keeps its contents in an on-chip array. It watches active-low row strobe, column strobe, write enable and output enable, together with a multiplexed address bus. The data pin is split into an input, an output and an output-enable. All pins are sampled on a system clock, and strobe edges are found by comparing each pin with its value at the previous clock edge.

A row is opened by a falling row strobe. Columns inside the open row are then accessed by falling column strobes. A two-bit mode input picks one of three access styles:
- plain page access, where read data is shown only while the column strobe is low;
- extended hold, where read data stays on the pins after the column strobe rises;
- nibble access, where only the first column address comes from the pins and the next three are generated inside the block.

A column strobe that falls before the row strobe starts a refresh cycle. During that cycle the pins are ignored, and an internal row counter chooses the row. The next refresh row and a running refresh count are brought out so that a bench can confirm the refresh rate.

Top module: `dram_emu`

## Requirements
- R1: The row address is captured at the clock edge that first sees the row strobe low while the column strobe is high. That row stays selected, whatever the address bus carries, until the row strobe goes high.
- R2: At each clock edge that first sees the column strobe low inside an open row, the column address is captured. If write enable is low at that edge, `dIn` is stored to the selected cell. If it is high, the cell is read into the output register.
- R3: In page mode (`accessMode` = 2'b00) and nibble mode (2'b10), `dOe` is high only after a read, and only while the row strobe and column strobe are low, write enable is high and output enable is low. It drops once the column strobe rises.
- R4: In hold mode (`accessMode` = 2'b01), read data stays on `dOut` with `dOe` high after the column strobe rises. It ends when the row strobe rises or a new column strobe fall selects another cell.
- R5: In nibble mode, the first column strobe of a row uses the external column address. Each later strobe in that row increments the low two column bits, wrapping inside the aligned group of four, and ignores the address bus.
- R6: A column strobe low at the edge where the row strobe falls starts a refresh cycle. The refresh touches no stored data and never drives `dOe`, whatever the address, write enable and `dIn` pins carry.
- R7: `refreshRow` names the row the next refresh will use. It advances by one per refresh and wraps from the last row to 0.
- R8: `refreshCount` increases by exactly one per refresh cycle.
- R9: After reset, `dOe` is low and `refreshRow` and `refreshCount` are 0.
- R10: A write access never drives `dOe`, even with output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all pins are sampled |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dIn | input | DATA_W | Write data |
| accessMode | input | 2 | 00 page, 01 hold, 10 nibble, 11 treated as page |
| dOut | output | DATA_W | Read data |
| dOe | output | 1 | High when `dOut` should drive the data pin |
| refreshRow | output | ROW_BITS | Row the next refresh will use |
| refreshCount | output | CNT_W | Number of refresh cycles since reset |

## Verification
The assertions assume that strobes move no more than once per clock. They also assume that a column strobe never falls in the same clock as the row strobe, and that at least one clock separates the row fall from the first column fall. The bench meets these assumptions by changing pins only at the falling clock edge and by holding every strobe level for at least one full clock. It also keeps `accessMode` constant for the whole of each row-open period, so no mode change happens while a row is open.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

  typedef enum logic [1:0] {
    MODE_PAGE   = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_NIBBLE = 2'b10,
    MODE_RSVD   = 2'b11
  } accessMode_e;

  typedef struct packed {
    logic rowLoad;     // open a row from the address bus
    logic refresh;     // refresh cycle on the internal row counter
    logic colAccess;   // column access inside the open row
    logic nibbleStep;  // column comes from the internal increment
    logic write;       // column access stores dIn
  } ctrlStrobes_t;

endpackage

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_emu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rasN,
  input  logic         casN,
  input  logic         weN,
  input  logic         oeN,
  input  logic [1:0]   accessMode,
  output ctrlStrobes_t strobes,
  output logic         dOe
);

  accessMode_e modeSel;
  logic rasPrev, casPrev;
  logic rowOpen, firstPending, dataValid;
  logic rasFall, casFall, holdMode;

  assign modeSel  = accessMode_e'(accessMode);
  assign holdMode = (modeSel == MODE_HOLD);
  assign rasFall  = rasPrev & ~rasN;
  assign casFall  = casPrev & ~casN;

  always_comb begin
    strobes.rowLoad    = rasFall & casN;
    strobes.refresh    = rasFall & ~casN;
    strobes.colAccess  = casFall & ~rasN & rowOpen;
    strobes.nibbleStep = strobes.colAccess & (modeSel == MODE_NIBBLE) & ~firstPending;
    strobes.write      = strobes.colAccess & ~weN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPrev      <= 1'b1;
      casPrev      <= 1'b1;
      rowOpen      <= 1'b0;
      firstPending <= 1'b0;
      dataValid    <= 1'b0;
    end else begin
      rasPrev <= rasN;
      casPrev <= casN;
      if (rasN)                 rowOpen <= 1'b0;
      else if (strobes.rowLoad) rowOpen <= 1'b1;
      if (strobes.rowLoad)        firstPending <= 1'b1;
      else if (strobes.colAccess) firstPending <= 1'b0;
      if (rasN)                   dataValid <= 1'b0;
      else if (strobes.colAccess) dataValid <= weN;
    end
  end

  // Stale data is never shown in the half clock before a new access lands.
  assign dOe = dataValid & ~rasN & weN & ~oeN & ~casFall & (~casN | holdMode);

  assert_col_in_open_row_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.colAccess |-> !$past(rasN));

  assert_refresh_no_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refresh |-> !strobes.colAccess && !dOe);

  assert_hold_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && rasN) |=> !dataValid);

  assert_write_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.write |=> !dOe);

endmodule

// File: rtl/dram_datapath.sv
module dram_datapath
  import dram_emu_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dIn,
  output logic [DATA_W-1:0]   dOut,
  output logic [ROW_BITS-1:0] refreshRow,
  output logic [CNT_W-1:0]    refreshCount
);

  localparam int WORDS = (1 << ROW_BITS) * (1 << COL_BITS);
  localparam logic [COL_BITS-1:0] LOW_MASK = COL_BITS'(3);

  logic [DATA_W-1:0]   mem [WORDS];
  logic [ROW_BITS-1:0] rowAddr;
  logic [COL_BITS-1:0] colAddr, colNext, colInc;
  logic [ROW_BITS+COL_BITS-1:0] cellIdx;

  assign colInc  = colAddr + COL_BITS'(1);
  assign colNext = strobes.nibbleStep ? ((colAddr & ~LOW_MASK) | (colInc & LOW_MASK))
                                      : addr[COL_BITS-1:0];
  assign cellIdx = {rowAddr, colNext};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAddr      <= '0;
      colAddr      <= '0;
      dOut         <= '0;
      refreshRow   <= '0;
      refreshCount <= '0;
    end else begin
      if (strobes.rowLoad) rowAddr <= addr[ROW_BITS-1:0];
      if (strobes.refresh) begin
        refreshRow   <= refreshRow + ROW_BITS'(1);
        refreshCount <= refreshCount + CNT_W'(1);
      end
      if (strobes.colAccess) begin
        colAddr <= colNext;
        if (!strobes.write) dOut <= mem[cellIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.write) mem[cellIdx] <= dIn;
  end

  assert_row_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rowLoad |=> $stable(rowAddr));

  assert_nibble_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nibbleStep |=> (colAddr[1:0] == $past(colAddr[1:0]) + 2'd1) &&
                           ((colAddr >> 2) == ($past(colAddr) >> 2)));

  assert_refresh_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.refresh && (&refreshRow)) |=> refreshRow == '0);

  assert_refresh_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refresh |=> refreshCount == $past(refreshCount) + CNT_W'(1));

endmodule

// File: rtl/dram_emu.sv
module dram_emu
  import dram_emu_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dIn,
  input  logic [1:0]          accessMode,
  output logic [DATA_W-1:0]   dOut,
  output logic                dOe,
  output logic [ROW_BITS-1:0] refreshRow,
  output logic [CNT_W-1:0]    refreshCount
);

  ctrlStrobes_t strobes;

  dram_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .oeN        (oeN),
    .accessMode (accessMode),
    .strobes    (strobes),
    .dOe        (dOe)
  );

  dram_datapath #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .addr         (addr),
    .dIn          (dIn),
    .dOut         (dOut),
    .refreshRow   (refreshRow),
    .refreshCount (refreshCount)
  );

endmodule

// File: tb/test_dram_emu.sv
module test_dram_emu;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int COLS = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] dIn = '0;
  logic [1:0] accessMode = 2'b00;
  logic [7:0] dOut;
  logic       dOe;
  logic [2:0] refreshRow;
  logic [15:0] refreshCount;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_emu i_dram_emu (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .accessMode(accessMode), .dOut(dOut), .dOe(dOe),
    .refreshRow(refreshRow), .refreshCount(refreshCount)
  );

  function automatic logic [7:0] pattern(int r, int c);
    return 8'((r * 37 + c * 11 + 5) % 256);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic openRow(int r);
    addr = 3'(r); rasN = 1'b0; tick();
  endtask

  task automatic closeRow();
    casN = 1'b1; weN = 1'b1; rasN = 1'b1; tick();
  endtask

  task automatic casWrite(int c, logic [7:0] d);
    addr = 3'(c); dIn = d; weN = 1'b0; oeN = 1'b0; casN = 1'b0; tick();
    chk("R10", "dOe on write", 32'(dOe), 32'd0);
    casN = 1'b1; weN = 1'b1; tick();
  endtask

  // Leaves the column strobe low after the check.
  task automatic casReadLow(int c, logic [7:0] exp, string req);
    addr = 3'(c); weN = 1'b1; oeN = 1'b0; casN = 1'b0; tick();
    chk(req, "dOe", 32'(dOe), 32'd1);
    chk(req, "dOut", 32'(dOut), 32'(exp));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "dOe", 32'(dOe), 32'd0);
    chk("R9", "refreshRow", 32'(refreshRow), 32'd0);
    chk("R9", "refreshCount", 32'(refreshCount), 32'd0);
    rstN = 1'b1; tick();

    // R2: fill every cell in page mode
    accessMode = 2'b00;
    for (int r = 0; r < ROWS; r++) begin
      openRow(r);
      for (int c = 0; c < COLS; c++) casWrite(c, pattern(r, c));
      closeRow();
    end

    // R1/R2/R3: page-mode read of every cell, reading columns in reverse order
    for (int r = 0; r < ROWS; r++) begin
      openRow(r);
      for (int c = COLS - 1; c >= 0; c--) begin
        casReadLow(c, pattern(r, c), "R1_R2");
        casN = 1'b1; tick();
        chk("R3", "dOe after cas rise", 32'(dOe), 32'd0);
      end
      closeRow();
    end

    // R3: output enable high suppresses drive; write enable high needed
    openRow(2);
    addr = 3'd4; oeN = 1'b1; casN = 1'b0; tick();
    chk("R3", "dOe with oe high", 32'(dOe), 32'd0);
    oeN = 1'b0; tick();
    chk("R3", "dOe oe lowered", 32'(dOe), 32'd1);
    chk("R3", "dOut", 32'(dOut), 32'(pattern(2, 4)));
    weN = 1'b0; #1;
    chk("R3", "dOe with we low", 32'(dOe), 32'd0);
    closeRow();

    // R4: hold mode keeps data after column strobe rises
    accessMode = 2'b01;
    openRow(5);
    casReadLow(3, pattern(5, 3), "R4");
    casN = 1'b1; tick();
    chk("R4", "dOe held", 32'(dOe), 32'd1);
    chk("R4", "dOut held", 32'(dOut), 32'(pattern(5, 3)));
    tick();
    chk("R4", "dOut still held", 32'(dOut), 32'(pattern(5, 3)));
    casReadLow(6, pattern(5, 6), "R4");
    casN = 1'b1; tick();
    chk("R4", "new col held", 32'(dOut), 32'(pattern(5, 6)));
    rasN = 1'b1; tick();
    chk("R4", "dOe after ras rise", 32'(dOe), 32'd0);
    tick();

    // R5: nibble read starting at col 6 -> 6,7,4,5; address bus carries junk
    accessMode = 2'b10;
    openRow(3);
    casReadLow(6, pattern(3, 6), "R5");
    casN = 1'b1; tick();
    chk("R5", "dOe between pulses", 32'(dOe), 32'd0);
    for (int k = 1; k < 4; k++) begin
      casReadLow(k, pattern(3, 4 + ((6 + k) % 4)), "R5");
      casN = 1'b1; tick();
    end
    closeRow();

    // R5: nibble write from col 1 -> 1,2,3,0, then page-mode verify
    openRow(7);
    casWrite(1, 8'hA0);
    for (int k = 1; k < 4; k++) casWrite(7, 8'(8'hA0 + k));
    closeRow();
    accessMode = 2'b00;
    openRow(7);
    for (int k = 0; k < 4; k++) begin
      casReadLow((1 + k) % 4, 8'(8'hA0 + k), "R5");
      casN = 1'b1; tick();
    end
    casReadLow(4, pattern(7, 4), "R5");
    closeRow();

    // R6/R7/R8: refresh cycles with junk on the pins, through a full wrap
    for (int k = 0; k < ROWS + 2; k++) begin
      chk("R7", "refreshRow before", 32'(refreshRow), 32'(k % ROWS));
      casN = 1'b0; oeN = 1'b0; weN = 1'(k % 2); dIn = 8'hFF; tick();
      addr = 3'(k ^ 5); rasN = 1'b0; tick();
      chk("R8", "refreshCount", 32'(refreshCount), 32'(k + 1));
      chk("R7", "refreshRow after", 32'(refreshRow), 32'((k + 1) % ROWS));
      chk("R6", "dOe in refresh", 32'(dOe), 32'd0);
      rasN = 1'b1; casN = 1'b1; weN = 1'b1; tick();
    end

    // R6: refresh left stored data alone
    for (int r = 0; r < 6; r++) begin
      openRow(r);
      casReadLow(r, pattern(r, r), "R6");
      closeRow();
    end

    finished = 1'b1;
    summary();
  end

endmodule